// File: doc/BRIEF.md
# Five-State Recovering Counter Built on JK Storage

This block is a 3-bit synchronous counter that follows a fixed, non-binary cycle of five codes: 0, 2, 3, 4, 7, then back to 0. Each state bit is stored in its own JK flip-flop. Combinational excitation logic works out the next code and then derives the J and K drive for each bit. The three codes outside the cycle (1, 5 and 6) always lead to code 7, so a corrupted state rejoins the cycle after one enabled step.

The counter advances on a rising clock edge only while the count enable is high. When the enable is low, every J and K is driven to zero and the state holds. An active-low asynchronous reset returns the counter to 0, which is the first code of the cycle. The per-bit J and K drive signals are outputs, so the excitation can be checked against the stored state from outside the block.

Top module: `seqcnt_jk`

## Requirements
- R1: While rst_n is low, state is 000 at once, without waiting for a clock edge, and it stays 000 for as long as rst_n remains low.
- R2: On each rising clock edge with cnt_en high, the state (bit 2 is the MSB) steps through the cycle 0 → 2 → 3 → 4 → 7 → 0.
- R3: From any of the codes 1, 5 or 6, the next rising edge with cnt_en high sets the state to 7.
- R4: While cnt_en is low, j_drv and k_drv are both 000, and the state does not change across rising clock edges.
- R5: While cnt_en is high, the excitation for each bit i is as follows, where n is the next code for the current state. j_drv[i] is 1 exactly when state[i]=0 and n[i]=1. k_drv[i] is 1 exactly when state[i]=1 and n[i]=0. All don't-care entries are therefore resolved to 0, so no bit ever receives J=K=1.
- R6: Each state bit obeys Q(t+1) = J·Q'(t) + K'·Q(t) on each rising edge, taking j_drv and k_drv as J and K. The four J,K cases are: 00 holds, 01 clears, 10 sets, 11 toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to code 000 |
| cnt_en | input | 1 | Count enable; when low, the state is held |
| state | output | 3 | Current code, bit 2 is the MSB |
| j_drv | output | 3 | J input driven into each bit's flip-flop |
| k_drv | output | 3 | K input driven into each bit's flip-flop |

## Verification
A fault in a stored bit shows at the state output straight away. Because j_drv and k_drv are derived from the state in the same cycle, a wrong code also appears in that cycle as an excitation pattern that does not match the expected next code. A fault in the excitation logic shows at j_drv and k_drv in the cycle where it occurs, and it corrupts the state on the next enabled edge. The bench checks the state and both drive vectors at every cycle, so a divergence is caught at most one clock after it starts. Codes outside the cycle cannot be reached through the ports, so the bench writes them into the flip-flops and checks that the counter recovers to 7 on the next enabled edge.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] START_CODE   = 3'd0;
  localparam logic [CNT_W-1:0] RECOVER_CODE = 3'd7;

  // next code of the five-state cycle; all other codes fall to recovery
  function automatic logic [CNT_W-1:0] next_code(input logic [CNT_W-1:0] cur);
    logic [CNT_W-1:0] n;
    case (cur)
      3'd0:    n = 3'd2;
      3'd2:    n = 3'd3;
      3'd3:    n = 3'd4;
      3'd4:    n = 3'd7;
      3'd7:    n = START_CODE;
      default: n = RECOVER_CODE;
    endcase
    return n;
  endfunction

  // JK characteristic: hold, clear, set, toggle
  function automatic logic jk_update(input logic j, input logic k, input logic q);
    return (j & ~q) | (~k & q);
  endfunction

  // excitation with don't-cares resolved to 0
  function automatic logic exc_j(input logic q, input logic n);
    return ~q & n;
  endfunction

  function automatic logic exc_k(input logic q, input logic n);
    return q & ~n;
  endfunction
endpackage

// File: rtl/seqcnt_jkcell.sv
module seqcnt_jkcell
  import seqcnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic j,
  input  logic k,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= jk_update(j, k, q_r);
  end

  assign q = q_r;
endmodule

// File: rtl/seqcnt_nextmap.sv
module seqcnt_nextmap
  import seqcnt_pkg::*;
(
  input  logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] nxt
);
  always_comb nxt = next_code(cur);
endmodule

// File: rtl/seqcnt_excite.sv
module seqcnt_excite
  import seqcnt_pkg::*;
(
  input  logic             en,
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] nxt,
  output logic [CNT_W-1:0] j,
  output logic [CNT_W-1:0] k
);
  for (genvar b = 0; b < CNT_W; b++) begin : g_exc
    assign j[b] = en & exc_j(cur[b], nxt[b]);
    assign k[b] = en & exc_k(cur[b], nxt[b]);
  end
endmodule

// File: rtl/seqcnt_jk.sv
module seqcnt_jk
  import seqcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] state,
  output logic [CNT_W-1:0] j_drv,
  output logic [CNT_W-1:0] k_drv
);
  logic [CNT_W-1:0] cur_code;
  logic [CNT_W-1:0] nxt_code;

  seqcnt_nextmap u_map (
    .cur (cur_code),
    .nxt (nxt_code)
  );

  seqcnt_excite u_exc (
    .en  (cnt_en),
    .cur (cur_code),
    .nxt (nxt_code),
    .j   (j_drv),
    .k   (k_drv)
  );

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    seqcnt_jkcell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .j     (j_drv[b]),
      .k     (k_drv[b]),
      .q     (cur_code[b])
    );
  end

  assign state = cur_code;
endmodule

// File: rtl/seqcnt_jk_chk.sv
module seqcnt_jk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_en,
  input logic [2:0] state,
  input logic [2:0] j_drv,
  input logic [2:0] k_drv
);
  assert_reset_R1: assert property (@(posedge clk) !rst_n |-> state == 3'd0);

  assert_step0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && state == 3'd0) |=> state == 3'd2);
  assert_step2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && state == 3'd2) |=> state == 3'd3);
  assert_step3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && state == 3'd3) |=> state == 3'd4);
  assert_step4_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && state == 3'd4) |=> state == 3'd7);
  assert_step7_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && state == 3'd7) |=> state == 3'd0);

  assert_recover_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && (state == 3'd1 || state == 3'd5 || state == 3'd6)) |=> state == 3'd7);

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> (j_drv == 3'd0 && k_drv == 3'd0));

  assert_excite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |-> ((j_drv & k_drv) == 3'd0 && (j_drv & state) == 3'd0 && (k_drv & ~state) == 3'd0));

  assert_law_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> state == (($past(j_drv) & ~$past(state)) | (~$past(k_drv) & $past(state))));
endmodule

bind seqcnt_jk seqcnt_jk_chk u_chk (.*);

// File: tb/tb_seqcnt_jk.sv
`timescale 1ns/1ps
module tb_seqcnt_jk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [2:0] state, j_drv, k_drv;

  seqcnt_jk dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .state  (state),
    .j_drv  (j_drv),
    .k_drv  (k_drv)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [2:0] s;
    logic [2:0] j;
    logic [2:0] k;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;
  logic [2:0] m_state = 3'd0;
  logic       m_en = 1'b0;
  int         succ_tab [8] = '{2, 7, 3, 4, 7, 7, 7, 0};

  function automatic void calc_jk(input logic [2:0] s, input logic en,
                                  output logic [2:0] jj, output logic [2:0] kk);
    logic [2:0] n;
    n = 3'(succ_tab[s]);
    for (int b = 0; b < 3; b++) begin
      jj[b] = en && s[b] == 1'b0 && n[b] == 1'b1;
      kk[b] = en && s[b] == 1'b1 && n[b] == 1'b0;
    end
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.s = m_state;
    calc_jk(m_state, m_en, e.j, e.k);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // one clock: model the edge with the previous enable, then set a new one
  task automatic step(input logic en, input string tag);
    @(posedge clk); #2;
    if (m_en && rst_n) m_state = 3'(succ_tab[m_state]);
    m_en = en;
    cnt_en = en;
    push_exp(tag);
  endtask

  task automatic inject(input logic [2:0] c);
    @(posedge clk); #2;
    force dut.g_bit[0].u_cell.q_r = c[0];
    force dut.g_bit[1].u_cell.q_r = c[1];
    force dut.g_bit[2].u_cell.q_r = c[2];
    #1;
    release dut.g_bit[0].u_cell.q_r;
    release dut.g_bit[1].u_cell.q_r;
    release dut.g_bit[2].u_cell.q_r;
    m_state = c;
    m_en = 1'b1;
    cnt_en = 1'b1;
    push_exp("R3");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (state !== e.s) begin
        n_bad++;
        $display("FAIL %s state actual=%0d expected=%0d", e.tag, state, e.s);
      end
      n_chk++;
      if (j_drv !== e.j || k_drv !== e.k) begin
        n_bad++;
        $display("FAIL %s j/k actual=%b/%b expected=%b/%b", (m_en ? "R5" : "R4"),
                 j_drv, k_drv, e.j, e.k);
      end
    end
  end

  initial begin
    // R1: reset state at start
    #3;
    n_chk++;
    if (state !== 3'd0) begin
      n_bad++;
      $display("FAIL R1 state actual=%0d expected=0", state);
    end
    step(1'b0, "R1");
    @(posedge clk); #1; rst_n = 1'b1;
    // two laps with R2 and R6 on each enabled edge
    for (int i = 0; i < 10; i++) step(1'b1, "R2 R6");
    step(1'b0, "R2");
    // R4: hold with enable low, mid-cycle
    step(1'b1, "R2");
    step(1'b1, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, "R4");
    step(1'b1, "R4");
    step(1'b0, "R2");
    // R3: each unused code recovers to 7
    inject(3'd1);
    step(1'b0, "R3");
    inject(3'd5);
    step(1'b0, "R3");
    inject(3'd6);
    step(1'b0, "R3");
    step(1'b1, "R2");
    step(1'b1, "R2");
    step(1'b0, "R2");
    // R1: asynchronous reset mid-run, checked before any edge
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    n_chk++;
    if (state !== 3'd0) begin
      n_bad++;
      $display("FAIL R1 async state actual=%0d expected=0", state);
    end
    m_state = 3'd0;
    m_en = 1'b0;
    cnt_en = 1'b0;
    push_exp("R1");
    step(1'b1, "R1");
    m_en = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
    m_en = 1'b1;
    push_exp("R1");
    step(1'b1, "R2");
    step(1'b0, "R2");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule